// File: doc/BRIEF.md
# DRAM Mode Register Command Tracker

This block keeps the mode register of a DDR2-style memory model. It watches the command strobes, the bank-address bits and the address bus every clock. When it sees a LOAD MODE command aimed at the mode register, it captures all thirteen mode bits in one write. From those bits it drives the decoded fields: burst length, burst type, CAS latency, test mode, DLL reset, write recovery and power-down mode. A load is legal only when the per-bank status vector shows every bank precharged. A load that breaks that rule is refused and reported on the error output.

After an accepted load, a small timer state machine has two named states. MRD_IDLE moves to MRD_WAIT on an accepted load. MRD_WAIT stays put while its countdown is non-zero, stays put and restarts on another accepted load, and returns to MRD_IDLE when the count reaches zero. The busy flag is high exactly while the machine is in MRD_WAIT. An ACTIVE command that arrives while busy is high is reported as an error. The DLL-reset field clears itself one cycle after it is written.

Top module: `dram_mode_tracker`

## Requirements
- R1: Commands are decoded from active-low strobes. LOAD MODE is cs_n, ras_n, cas_n and we_n all 0. ACTIVE is cs_n=0, ras_n=0, cas_n=1, we_n=1. With cs_n=1 no command is seen, whatever the other strobes are.
- R2: A LOAD MODE with bank_addr all zero and bank_open all zero writes addr[12:0] into the mode fields at the next clock edge. All fields are written together. Address bits above bit 12 are ignored.
- R3: The field layout is fixed. addr[2:0] is burst length and addr[3] is burst type (1 = interleaved). addr[6:4] is CAS latency, addr[7] is test mode and addr[8] is DLL reset. addr[11:9] is write recovery and addr[12] is power-down mode.
- R4: dll_reset reads 1 for exactly one cycle after a load that wrote it as 1, then reads 0. No other field changes except on a load.
- R5: A LOAD MODE with a non-zero bank_addr has no effect on the fields, busy or error.
- R6: A LOAD MODE with bank_addr zero while any bit of bank_open is 1 is refused. The fields keep their previous values, busy does not start, and error is raised.
- R7: busy is high for exactly MRD_CYCLES cycles after an accepted load. An accepted load while busy restarts the full count.
- R8: An ACTIVE command sampled while busy is high raises error. An ACTIVE sampled while busy is low does not.
- R9: error is registered. It is high for one cycle, in the cycle after the offending command, and low otherwise.
- R10: Reset (rst_n low, asynchronous) clears every field, busy and error to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| bank_addr | input | BA_W | Bank address; all zero selects the mode register |
| addr | input | ADDR_W | Address bus carrying the mode bits |
| bank_open | input | NUM_BANKS | Per-bank status, 1 = open, 0 = precharged |
| burst_len | output | 3 | Burst length code |
| burst_ilv | output | 1 | Burst type, 1 = interleaved |
| cas_lat | output | 3 | CAS latency code |
| test_mode | output | 1 | Test mode bit |
| dll_reset | output | 1 | Self-clearing DLL-reset bit |
| write_rec | output | 3 | Write recovery code |
| pd_mode | output | 1 | Power-down mode bit |
| busy | output | 1 | Mode-register delay window in progress |
| error | output | 1 | One-cycle pulse on an illegal command |

## Verification
The bench builds the block with MRD_CYCLES=3, NUM_BANKS=8, BA_W=3 and ADDR_W=14.

A three-cycle window lets an ACTIVE land on the last busy cycle and then on the first free cycle. It also lets a second load restart a window that is already running.

Eight banks let the refusal be tested with a middle bank open and with the highest bank open. Setting address bit 13 checks that bits above the field range are ignored.

// File: rtl/dram_mr_pkg.sv
package dram_mr_pkg;

    localparam int MR_W = 13;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_LOAD_MODE,
        CMD_ACTIVE,
        CMD_OTHER
    } dram_cmd_e;

    typedef enum logic {
        MRD_IDLE,
        MRD_WAIT
    } mrd_state_e;

    typedef struct packed {
        logic       pd_mode;
        logic [2:0] write_rec;
        logic       dll_reset;
        logic       test_mode;
        logic [2:0] cas_lat;
        logic       burst_ilv;
        logic [2:0] burst_len;
    } mode_fields_t;

endpackage

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
    import dram_mr_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    output dram_cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_NONE;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_LOAD_MODE;
                3'b011:  cmd = CMD_ACTIVE;
                3'b111:  cmd = CMD_NONE;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/dram_mr_store.sv
module dram_mr_store
    import dram_mr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [MR_W-1:0] mr_bits_i,
    output mode_fields_t    fields_o
);

    mode_fields_t fields_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else if (load_i) begin
            fields_q <= mode_fields_t'(mr_bits_i);
        end else begin
            fields_q.dll_reset <= 1'b0;
        end
    end

    assign fields_o = fields_q;

    // R2
    load_writes_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (fields_q == mode_fields_t'($past(mr_bits_i))));

    // R4
    dll_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fields_q.dll_reset && !load_i) |=> !fields_q.dll_reset);

    // R4
    hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ({fields_q.pd_mode, fields_q.write_rec, fields_q.test_mode,
                      fields_q.cas_lat, fields_q.burst_ilv, fields_q.burst_len}
                     == $past({fields_q.pd_mode, fields_q.write_rec, fields_q.test_mode,
                               fields_q.cas_lat, fields_q.burst_ilv, fields_q.burst_len})));

endmodule

// File: rtl/dram_mrd_timer.sv
module dram_mrd_timer
    import dram_mr_pkg::*;
#(
    parameter int MRD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);

    localparam int CNT_W = (MRD_CYCLES < 2) ? 1 : $clog2(MRD_CYCLES);
    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(MRD_CYCLES - 1);

    mrd_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            MRD_IDLE: begin
                if (load_i) begin
                    state_d = MRD_WAIT;
                    cnt_d   = CNT_START;
                end
            end
            MRD_WAIT: begin
                if (load_i) begin
                    cnt_d = CNT_START;
                end else if (cnt_q == '0) begin
                    state_d = MRD_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = MRD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MRD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy_o = (state_q == MRD_WAIT);
    end

    // R7
    load_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o);

    // R7
    busy_ends_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(cnt_q) == '0 && !$past(load_i)));

endmodule

// File: rtl/dram_mode_tracker.sv
module dram_mode_tracker
    import dram_mr_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int BA_W       = 3,
    parameter int NUM_BANKS  = 8,
    parameter int MRD_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      bank_addr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_BANKS-1:0] bank_open,
    output logic [2:0]           burst_len,
    output logic                 burst_ilv,
    output logic [2:0]           cas_lat,
    output logic                 test_mode,
    output logic                 dll_reset,
    output logic [2:0]           write_rec,
    output logic                 pd_mode,
    output logic                 busy,
    output logic                 error
);

    dram_cmd_e    cmd;
    mode_fields_t fields;
    logic         mr_sel, any_open, load_ok, load_bad, act_early, error_q;

    dram_cmd_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign mr_sel    = (cmd == CMD_LOAD_MODE) && (bank_addr == '0);
    assign any_open  = |bank_open;
    assign load_ok   = mr_sel && !any_open;
    assign load_bad  = mr_sel && any_open;
    assign act_early = (cmd == CMD_ACTIVE) && busy;

    dram_mr_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_ok),
        .mr_bits_i (addr[MR_W-1:0]),
        .fields_o  (fields)
    );

    dram_mrd_timer #(.MRD_CYCLES(MRD_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_ok),
        .busy_o (busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            error_q <= 1'b0;
        end else begin
            error_q <= load_bad || act_early;
        end
    end

    assign error     = error_q;
    assign burst_len = fields.burst_len;
    assign burst_ilv = fields.burst_ilv;
    assign cas_lat   = fields.cas_lat;
    assign test_mode = fields.test_mode;
    assign dll_reset = fields.dll_reset;
    assign write_rec = fields.write_rec;
    assign pd_mode   = fields.pd_mode;

    // R6
    refused_load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD_MODE && bank_addr == '0 && bank_open != '0) |=> (error && $stable(cas_lat)));

    // R8
    early_active_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACTIVE && busy) |=> error);

    // R5
    other_bank_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD_MODE && bank_addr != '0 && !busy) |=> (!busy && !error));

endmodule

// File: tb/dram_mode_tracker_tb_top.sv
module dram_mode_tracker_tb_top;

    localparam int ADDR_W = 14;
    localparam int BA_W   = 3;
    localparam int NB     = 8;
    localparam int MRD    = 3;
    localparam int NVEC   = 15;

    // vector: cmd[41:40] ba[39:37] addr[36:23] open[22:15] exp_mr[14:2] busy[1] err[0]
    // cmd: 0 none, 1 load mode, 2 active, 3 strobes low with cs_n high
    localparam logic [41:0] VEC [NVEC] = '{
        {2'd1, 3'd0, 14'h1B4B, 8'h00, 13'h1B4B, 1'b1, 1'b0}, // R2 R3 R4 all fields written
        {2'd0, 3'd0, 14'h0000, 8'h00, 13'h1A4B, 1'b1, 1'b0}, // R4 dll bit clears
        {2'd0, 3'd0, 14'h0000, 8'h00, 13'h1A4B, 1'b1, 1'b0},
        {2'd2, 3'd0, 14'h0000, 8'h00, 13'h1A4B, 1'b0, 1'b1}, // R8 active in last busy cycle
        {2'd2, 3'd0, 14'h0000, 8'h00, 13'h1A4B, 1'b0, 1'b0}, // R8 first free cycle
        {2'd1, 3'd0, 14'h0FFF, 8'h04, 13'h1A4B, 1'b0, 1'b1}, // R6 bank 2 open
        {2'd0, 3'd0, 14'h0000, 8'h00, 13'h1A4B, 1'b0, 1'b0}, // R9 pulse ends
        {2'd1, 3'd2, 14'h0FFF, 8'h00, 13'h1A4B, 1'b0, 1'b0}, // R5 other bank
        {2'd1, 3'd0, 14'h2032, 8'h00, 13'h0032, 1'b1, 1'b0}, // R2 bit 13 ignored
        {2'd1, 3'd0, 14'h0108, 8'h00, 13'h0108, 1'b1, 1'b0}, // R7 restart
        {2'd0, 3'd0, 14'h0000, 8'h00, 13'h0008, 1'b1, 1'b0},
        {2'd0, 3'd0, 14'h0000, 8'h00, 13'h0008, 1'b1, 1'b0},
        {2'd0, 3'd0, 14'h0000, 8'h00, 13'h0008, 1'b0, 1'b0}, // R7 window over
        {2'd3, 3'd0, 14'h1FFF, 8'h00, 13'h0008, 1'b0, 1'b0}, // R1 deselected
        {2'd1, 3'd0, 14'h1FFF, 8'h80, 13'h0008, 1'b0, 1'b1}  // R6 top bank open
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [BA_W-1:0]   bank_addr = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [NB-1:0]     bank_open = '0;
    logic [2:0] burst_len, cas_lat, write_rec;
    logic burst_ilv, test_mode, dll_reset, pd_mode, busy, error;
    logic [12:0] mr_view;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dram_mode_tracker #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .NUM_BANKS(NB), .MRD_CYCLES(MRD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank_addr(bank_addr), .addr(addr), .bank_open(bank_open),
        .burst_len(burst_len), .burst_ilv(burst_ilv), .cas_lat(cas_lat),
        .test_mode(test_mode), .dll_reset(dll_reset), .write_rec(write_rec),
        .pd_mode(pd_mode), .busy(busy), .error(error)
    );

    assign mr_view = {pd_mode, write_rec, dll_reset, test_mode, cas_lat, burst_ilv, burst_len};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] c, input logic [BA_W-1:0] ba,
                         input logic [ADDR_W-1:0] a, input logic [NB-1:0] op);
        unique case (c)
            2'd0: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            2'd1: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
            2'd2: {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b1000;
        endcase
        bank_addr = ba;
        addr      = a;
        bank_open = op;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R10 reset state
        check("R10 fields", 32'(mr_view), 32'h0);
        check("R10 busy", 32'(busy), 32'h0);
        check("R10 error", 32'(error), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][41:40], VEC[i][39:37], VEC[i][36:23], VEC[i][22:15]);
            check("R2 fields", 32'(mr_view), 32'(VEC[i][14:2]));
            check("R7 busy", 32'(busy), 32'(VEC[i][1]));
            check("R9 error", 32'(error), 32'(VEC[i][0]));
        end

        // R10 reset during the busy window
        drive(2'd1, '0, 14'h1FFF, '0);
        check("R7 busy before reset", 32'(busy), 32'h1);
        rst_n = 1'b0;
        #1;
        check("R10 busy cleared", 32'(busy), 32'h0);
        check("R10 fields cleared", 32'(mr_view), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R8 active after reset is not early
        drive(2'd2, '0, '0, '0);
        check("R8 active idle", 32'(error), 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule